// File: doc/BRIEF.md
# Two-Level Occupancy Bitmap Next-Slot Finder

This block keeps track of which slots of a timing wheel currently hold any entries, so that the wheel's trailing pointer can jump straight to the next occupied slot on every clock tick instead of stepping through empty slots. Each slot has one occupancy bit. The bits are packed into words, and a summary vector holds one bit per word that is set whenever that word has any bit set.

A query presents a slot position. The block looks first in the word that holds the position, with the bits below the position masked off. If that fails, it uses the summary vector to pick the first non-empty word above the position. If there is none, it wraps to the lowest non-empty word. Two dependent reads (summary, then one bit word) give the answer in a fixed time, and the result is registered one cycle after the query. Separate set and clear ports update the bit words and the summary together. The wheel's list storage lives elsewhere.

Top module: `ffw_next_slot`

## Requirements
- R1: After reset every slot is empty, `res_vld` is 0, and a query returns `res_found` = 0.
- R2: `res_vld` is 1 in exactly the cycle after a cycle in which `qry_vld` is 1.
- R3: If any slot with an index at or above `qry_pos` in the same word as `qry_pos` is occupied, the lowest such slot is returned with `res_found` = 1. The slot index is {word number, bit number}, and the bit number sits in the low log2(WORD_W) bits.
- R4: If the word holding `qry_pos` has nothing at or above the position, the lowest occupied slot in the first non-empty higher word is returned.
- R5: If no slot at or above `qry_pos` is occupied but some slot is, the search wraps, and the lowest occupied slot of the whole bitmap is returned. This includes slots below the position in its own word.
- R6: With an empty bitmap a query returns `res_found` = 0 and `res_idx` = 0.
- R7: A query sees the bitmap as it stood before the set and clear requests of its own cycle. Those updates are visible to queries from the next cycle on.
- R8: A set and a clear aimed at the same slot in the same cycle leave the slot occupied. A set and a clear aimed at different slots both take effect.
- R9: When a clear empties a word, that word's summary bit drops at the same edge, so a query in the next cycle skips that word.
- R10: Setting an occupied slot, or clearing an empty one, changes nothing that a later query can see.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_vld | input | 1 | Mark slot `set_idx` occupied |
| set_idx | input | SLOT_W | Slot to mark occupied |
| clr_vld | input | 1 | Mark slot `clr_idx` empty |
| clr_idx | input | SLOT_W | Slot to mark empty |
| qry_vld | input | 1 | Start a next-slot search |
| qry_pos | input | SLOT_W | Position the search starts from |
| res_vld | output | 1 | Search result valid |
| res_found | output | 1 | An occupied slot was found |
| res_idx | output | SLOT_W | Next occupied slot at or after the position, with wrap |

## Verification
Searching and updating can fall in the same cycle, and so can a set and a clear. The random phase issues queries, sets and clears together in most cycles, often to slots in the same word. Each result is compared with a forward scan over a bench model frozen before that cycle's updates. Directed cycles aim a set and a clear at the same slot, set a slot while it is being searched for, and clear the only bit of a word. The following query then shows whether the update order and the summary bit were correct.

// File: rtl/ffw_pkg.sv
package ffw_pkg;
  localparam int unsigned LIMIT_W = 128;
  localparam int unsigned LIDX_W  = 7;

  // lowest set bit of a (zero-extended) vector; 0 when nothing is set
  function automatic logic [LIDX_W-1:0] lowest_one(input logic [LIMIT_W-1:0] v);
    logic [LIDX_W-1:0] r;
    r = '0;
    for (int i = LIMIT_W - 1; i >= 0; i--) begin
      if (v[i]) r = LIDX_W'(i);
    end
    return r;
  endfunction

  // ones at and above position start
  function automatic logic [LIMIT_W-1:0] mask_from(input int unsigned start);
    logic [LIMIT_W-1:0] m;
    if (start >= LIMIT_W) m = '0;
    else m = {LIMIT_W{1'b1}} << start;
    return m;
  endfunction
endpackage

// File: rtl/ffw_occ_store.sv
module ffw_occ_store #(
  parameter int unsigned WORD_W    = 8,
  parameter int unsigned NUM_WORDS = 8,
  localparam int unsigned BIT_W    = $clog2(WORD_W),
  localparam int unsigned WSEL_W   = $clog2(NUM_WORDS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          set_vld,
  input  logic [WSEL_W-1:0]             set_word,
  input  logic [BIT_W-1:0]              set_bit,
  input  logic                          clr_vld,
  input  logic [WSEL_W-1:0]             clr_word,
  input  logic [BIT_W-1:0]              clr_bit,
  output logic [NUM_WORDS*WORD_W-1:0]   occ_flat,
  output logic [NUM_WORDS-1:0]          sum_q
);
  logic [WORD_W-1:0] word_q [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_d;
    logic              hit_set;
    logic              hit_clr;

    assign hit_set = set_vld && (set_word == WSEL_W'(w));
    assign hit_clr = clr_vld && (clr_word == WSEL_W'(w));

    // clear first, then set: a set on the same slot wins
    always_comb begin
      word_d = word_q[w];
      if (hit_clr) word_d[clr_bit] = 1'b0;
      if (hit_set) word_d[set_bit] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q[w] <= '0;
        sum_q[w]  <= 1'b0;
      end else begin
        word_q[w] <= word_d;
        sum_q[w]  <= |word_d;
      end
    end

    assign occ_flat[w*WORD_W +: WORD_W] = word_q[w];
  end
endmodule

// File: rtl/ffw_word_pick.sv
module ffw_word_pick #(
  parameter int unsigned NUM_WORDS = 8,
  localparam int unsigned WSEL_W   = $clog2(NUM_WORDS)
) (
  input  logic [NUM_WORDS-1:0] sum_vec,
  input  logic [WSEL_W-1:0]    cur_word,
  input  logic                 cur_hit,
  output logic [WSEL_W-1:0]    pick_word,
  output logic                 pick_any,
  output logic                 pick_wrapped
);
  import ffw_pkg::*;

  logic [LIMIT_W-1:0] sum_ext;
  logic [LIMIT_W-1:0] above;

  always_comb begin
    sum_ext = '0;
    sum_ext[NUM_WORDS-1:0] = sum_vec;
    above = sum_ext & mask_from(int'(cur_word) + 1);
    pick_any     = |sum_vec;
    pick_wrapped = 1'b0;
    if (cur_hit) begin
      pick_word = cur_word;
    end else if (|above) begin
      pick_word = WSEL_W'(lowest_one(above));
    end else begin
      pick_word    = WSEL_W'(lowest_one(sum_ext));
      pick_wrapped = pick_any;
    end
  end
endmodule

// File: rtl/ffw_bit_pick.sv
module ffw_bit_pick #(
  parameter int unsigned WORD_W = 8,
  localparam int unsigned BIT_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] word_bits,
  input  logic [BIT_W-1:0]  start_bit,
  output logic [BIT_W-1:0]  bit_idx,
  output logic              bit_any
);
  import ffw_pkg::*;

  logic [LIMIT_W-1:0] ext;
  logic [LIMIT_W-1:0] masked;

  always_comb begin
    ext = '0;
    ext[WORD_W-1:0] = word_bits;
    masked  = ext & mask_from(int'(start_bit));
    bit_any = |masked;
    bit_idx = BIT_W'(lowest_one(masked));
  end
endmodule

// File: rtl/ffw_next_slot.sv
module ffw_next_slot #(
  parameter int unsigned WORD_W    = 8,
  parameter int unsigned NUM_WORDS = 8,
  localparam int unsigned BIT_W    = $clog2(WORD_W),
  localparam int unsigned WSEL_W   = $clog2(NUM_WORDS),
  localparam int unsigned SLOT_W   = BIT_W + WSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_vld,
  input  logic [SLOT_W-1:0] set_idx,
  input  logic              clr_vld,
  input  logic [SLOT_W-1:0] clr_idx,
  input  logic              qry_vld,
  input  logic [SLOT_W-1:0] qry_pos,
  output logic              res_vld,
  output logic              res_found,
  output logic [SLOT_W-1:0] res_idx
);
  logic [NUM_WORDS*WORD_W-1:0] occ_flat;
  logic [NUM_WORDS-1:0]        sum_q;

  ffw_occ_store #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vld  (set_vld),
    .set_word (set_idx[SLOT_W-1:BIT_W]),
    .set_bit  (set_idx[BIT_W-1:0]),
    .clr_vld  (clr_vld),
    .clr_word (clr_idx[SLOT_W-1:BIT_W]),
    .clr_bit  (clr_idx[BIT_W-1:0]),
    .occ_flat (occ_flat),
    .sum_q    (sum_q)
  );

  // search in the word holding the position, bits below it masked
  logic [WSEL_W-1:0] cur_word;
  logic [WORD_W-1:0] cur_bits;
  logic [BIT_W-1:0]  cur_idx;
  logic              cur_hit;

  assign cur_word = qry_pos[SLOT_W-1:BIT_W];
  assign cur_bits = occ_flat[cur_word*WORD_W +: WORD_W];

  ffw_bit_pick #(.WORD_W(WORD_W)) first_i (
    .word_bits (cur_bits),
    .start_bit (qry_pos[BIT_W-1:0]),
    .bit_idx   (cur_idx),
    .bit_any   (cur_hit)
  );

  // read one: summary vector chooses the word
  logic [WSEL_W-1:0] pick_word;
  logic              pick_any;
  logic              pick_wrapped;

  ffw_word_pick #(.NUM_WORDS(NUM_WORDS)) word_i (
    .sum_vec      (sum_q),
    .cur_word     (cur_word),
    .cur_hit      (cur_hit),
    .pick_word    (pick_word),
    .pick_any     (pick_any),
    .pick_wrapped (pick_wrapped)
  );

  // read two: chosen word, no mask
  logic [WORD_W-1:0] pick_bits;
  logic [BIT_W-1:0]  pick_idx;
  logic              pick_bit_any;

  assign pick_bits = occ_flat[pick_word*WORD_W +: WORD_W];

  ffw_bit_pick #(.WORD_W(WORD_W)) second_i (
    .word_bits (pick_bits),
    .start_bit ('0),
    .bit_idx   (pick_idx),
    .bit_any   (pick_bit_any)
  );

  // named search outcome, visible to the checker
  logic              srch_found;
  logic [SLOT_W-1:0] srch_idx;

  always_comb begin
    srch_found = pick_any && (cur_hit || pick_bit_any);
    if (!srch_found)  srch_idx = '0;
    else if (cur_hit) srch_idx = {cur_word, cur_idx};
    else              srch_idx = {pick_word, pick_idx};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld   <= 1'b0;
      res_found <= 1'b0;
      res_idx   <= '0;
    end else begin
      res_vld <= qry_vld;
      if (qry_vld) begin
        res_found <= srch_found;
        res_idx   <= srch_idx;
      end
    end
  end

  logic unused_wrap;
  assign unused_wrap = pick_wrapped;
endmodule

// File: rtl/ffw_next_slot_chk.sv
module ffw_next_slot_chk #(
  parameter int unsigned WORD_W    = 8,
  parameter int unsigned NUM_WORDS = 8,
  localparam int unsigned BIT_W    = $clog2(WORD_W),
  localparam int unsigned WSEL_W   = $clog2(NUM_WORDS),
  localparam int unsigned SLOT_W   = BIT_W + WSEL_W
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        set_vld,
  input logic [SLOT_W-1:0]           set_idx,
  input logic                        clr_vld,
  input logic [SLOT_W-1:0]           clr_idx,
  input logic                        qry_vld,
  input logic                        res_vld,
  input logic                        res_found,
  input logic [SLOT_W-1:0]           res_idx,
  input logic [NUM_WORDS*WORD_W-1:0] occ_flat,
  input logic [NUM_WORDS-1:0]        sum_q
);
  logic [NUM_WORDS-1:0]        sum_calc;
  logic [NUM_WORDS*WORD_W-1:0] prev_occ;
  logic                        prev_empty;

  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) sum_calc[w] = |occ_flat[w*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_occ   <= '0;
      prev_empty <= 1'b1;
    end else begin
      prev_occ   <= occ_flat;
      prev_empty <= (sum_q == '0);
    end
  end

  // R2
  a_r2_vld_follows_query: assert property (@(posedge clk) disable iff (!rst_n)
    qry_vld |=> res_vld);
  a_r2_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_n)
    !qry_vld |=> !res_vld);
  // R9: summary bit tracks its word at every edge
  a_r9_summary_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    sum_q == sum_calc);
  // R3 / R7: a returned slot was occupied in the query cycle
  a_r3_found_was_set: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_found) |-> prev_occ[res_idx]);
  // R6
  a_r6_empty_not_found: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && prev_empty) |-> (!res_found && res_idx == '0));
  // R8
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vld && clr_vld && set_idx == clr_idx) |=> occ_flat[$past(set_idx)]);
  // R8: a clear on another slot still lands
  a_r8_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vld && !(set_vld && set_idx == clr_idx)) |=> !occ_flat[$past(clr_idx)]);
endmodule

bind ffw_next_slot ffw_next_slot_chk #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .set_vld   (set_vld),
  .set_idx   (set_idx),
  .clr_vld   (clr_vld),
  .clr_idx   (clr_idx),
  .qry_vld   (qry_vld),
  .res_vld   (res_vld),
  .res_found (res_found),
  .res_idx   (res_idx),
  .occ_flat  (occ_flat),
  .sum_q     (sum_q)
);

// File: tb/ffw_next_slot_tb_top.sv
module ffw_next_slot_tb_top;
  localparam int WW = 8;
  localparam int NW = 8;
  localparam int N  = WW * NW;
  localparam int SW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          set_vld = 1'b0, clr_vld = 1'b0, qry_vld = 1'b0;
  logic [SW-1:0] set_idx = '0, clr_idx = '0, qry_pos = '0;
  logic          res_vld, res_found;
  logic [SW-1:0] res_idx;

  always #4 clk = ~clk;

  ffw_next_slot #(.WORD_W(WW), .NUM_WORDS(NW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .set_vld(set_vld), .set_idx(set_idx),
    .clr_vld(clr_vld), .clr_idx(clr_idx),
    .qry_vld(qry_vld), .qry_pos(qry_pos),
    .res_vld(res_vld), .res_found(res_found), .res_idx(res_idx)
  );

  int    n_run = 0, n_fail = 0;
  bit    mdl [N];
  bit    pend = 1'b0, pend_found = 1'b0;
  int    pend_idx = 0;
  string pend_tag = "";
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // forward scan with wrap over the model
  task automatic scan(input int pos, output bit f, output int idx);
    f = 1'b0; idx = 0;
    for (int k = 0; k < N; k++) begin
      if (!f && mdl[(pos + k) % N]) begin
        f = 1'b1; idx = (pos + k) % N;
      end
    end
  endtask

  task automatic check_pending();
    chk(res_vld == pend, "R2 valid timing", int'(res_vld), int'(pend));
    if (pend && res_vld) begin
      chk(res_found == pend_found, {pend_tag, " found"}, int'(res_found), int'(pend_found));
      chk(int'(res_idx) == pend_idx, {pend_tag, " index"}, int'(res_idx), pend_idx);
    end
  endtask

  // one cycle: check last result, then drive new inputs
  task automatic step(input bit sv, input int si, input bit cv, input int ci,
                      input bit qv, input int qp, input string tag);
    bit f; int idx;
    @(negedge clk);
    check_pending();
    pend = qv;
    if (qv) begin
      scan(qp, f, idx);
      pend_found = f; pend_idx = idx;
      if (tag != "")                          pend_tag = tag;
      else if (!f)                            pend_tag = "R6 empty";
      else if (idx >= qp && idx / WW == qp / WW) pend_tag = "R3 same word";
      else if (idx > qp)                      pend_tag = "R4 later word";
      else                                    pend_tag = "R5 wrap";
    end
    if (cv) mdl[ci] = 1'b0;
    if (sv) mdl[si] = 1'b1;
    set_vld = sv; set_idx = SW'(si);
    clr_vld = cv; clr_idx = SW'(ci);
    qry_vld = qv; qry_pos = SW'(qp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < N; i++) mdl[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk(res_vld == 1'b0, "R1 reset valid", int'(res_vld), 0);
    rst_n = 1'b1;
    // R1 / R6: empty after reset
    step(0, 0, 0, 0, 1, 17, "R1 empty after reset");
    step(0, 0, 0, 0, 1, 63, "R6 empty at top");
    // R7: query in same cycle as set sees the old state
    step(1, 5, 0, 0, 1, 0, "R7 same-cycle set hidden");
    step(0, 0, 0, 0, 1, 0, "R7 set visible next");
    // R8: set and clear same slot, set wins
    step(1, 42, 1, 42, 0, 0, "");
    step(0, 0, 0, 0, 1, 40, "R8 set wins");
    // R8: different slots both apply
    step(1, 44, 1, 42, 0, 0, "");
    step(0, 0, 0, 0, 1, 40, "R8 both apply");
    // R9: empty word 2 by clearing its only bit
    step(1, 20, 0, 0, 0, 0, "");
    step(0, 0, 1, 20, 1, 16, "R7 clear hidden");
    step(0, 0, 0, 0, 1, 16, "R9 emptied word skipped");
    // R10: redundant set and clear
    step(1, 44, 0, 0, 0, 0, "");
    step(0, 0, 1, 30, 0, 0, "");
    step(0, 0, 0, 0, 1, 43, "R10 no effect");
    step(0, 0, 1, 44, 0, 0, "");
    step(0, 0, 0, 0, 1, 45, "R5 wrap low");
    step(0, 0, 0, 0, 1, 6, "R5 wrap same word");
    // random mix
    for (int c = 0; c < 4000; c++) begin
      int r = int'($urandom % 100);
      bit sv = ($urandom % 100) < ((r < 50) ? 45 : 15);
      bit cv = ($urandom % 100) < 40;
      bit qv = ($urandom % 100) < 80;
      int si = int'($urandom % N);
      int ci = (($urandom % 4) == 0) ? si : int'($urandom % N);
      step(sv, si, cv, ci, qv, int'($urandom % N), "");
    end
    step(0, 0, 0, 0, 0, 0, "");
    step(0, 0, 0, 0, 0, 0, "");
    finish_run();
  end
endmodule